// File: doc/BRIEF.md
# Three-Slot Bundle Issue Unit

This block takes 128-bit instruction bundles from a fetch stage. Each bundle holds a 5-bit template and three fixed-length 41-bit instruction slots. The block sends every slot to one of four typed issue ports: integer, memory, branch and floating-point. The template is written by the compiler. It fixes the unit type of each slot and marks stop points between slots. The slots between two stops make up one group, and a group leaves together in one cycle. No hardware dependency check is done inside a group, because the compiler guarantees that its members are independent.

A bundle is accepted on a valid/ready handshake and held in a single register. It issues starting in the cycle after acceptance. A stop, or two slots of one group that need the same unit type, splits the bundle across cycles. Slots never overtake an earlier waiting slot. Ready returns high in the cycle that issues the last pending slots, so bundles without splits stream one per cycle. Each issue port carries the slot's decoded opcode, predicate index, three register specifiers and modifier bits, plus the slot's position in the bundle. The predicate is only decoded and passed on; it does not gate issue. Templates outside the defined set are flagged as illegal and issue nothing.

Top module: `bundle_issue_unit`

## Requirements
- R1: Bundle layout: template in bits [4:0], slot k in bits [5+41k +: 41]. Inside a slot: opcode [40:37], modifiers [36:27], destination [26:20], source 1 [19:13], source 2 [12:6], predicate [5:0]. An issue port presents these fields of its slot and the slot position k on its idx output.
- R2: Issue port index = unit type: 0 integer, 1 memory, 2 branch, 3 floating-point. Template bits [3:2] select the unit types of slots 0,1,2: 0 → mem,int,int; 1 → mem,mem,int; 2 → mem,fp,int; 3 → mem,int,branch.
- R3: Template bits [1:0] set the stops: 0 none, 1 after slot 0, 2 after slot 1, 3 after slot 0 and after slot 1.
- R4: A legal bundle with no internal stop and no repeated unit type issues all three slots in the cycle after it is accepted.
- R5: A slot after a stop issues in a later cycle than every slot before that stop. The next group issues in the following cycle.
- R6: When a slot needs a unit already taken in the current cycle, that slot and all later slots of the bundle wait exactly one cycle, keeping program order.
- R7: A template with bit 4 set is illegal. In the cycle after acceptance, illegal_o is high for one cycle, no issue port is valid, and ready is high.
- R8: A bundle is accepted on a rising edge where valid and ready are both high. Ready is high when nothing is held or when the current cycle issues the last pending slots. Bundles that need no split issue on consecutive cycles.
- R9: While reset is asserted, ready is high, illegal_o is low and no issue port is valid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bnd_vld_i | input | 1 | Bundle valid from fetch |
| bnd_i | input | 128 | Bundle: template and three slots |
| bnd_rdy_o | output | 1 | Bundle ready toward fetch |
| illegal_o | output | 1 | Held bundle has an undefined template |
| iss_vld_o | output | 4 | Issue valid per unit type |
| iss_idx_o | output | 4x2 | Slot position of the issued slot per port |
| iss_opc_o | output | 4x4 | Opcode per port |
| iss_pred_o | output | 4x6 | Predicate index per port |
| iss_dst_o | output | 4x7 | Destination register per port |
| iss_src1_o | output | 4x7 | First source register per port |
| iss_src2_o | output | 4x7 | Second source register per port |
| iss_mod_o | output | 4x10 | Modifier bits per port |

## Verification
The assertions check these properties on every cycle:
- An illegal bundle issues nothing and frees the input at once.
- Slot 0 only ever leaves on the memory port.
- Every accepted bundle shows activity in the next cycle.
- A cycle with ready low always issues something and is followed by another issue cycle.

The bench's reference model is needed for the rest: which slots form each group for every one of the 32 template codes, the exact cycle in which a stopped or unit-conflicted slot leaves, the decoded field values, and back-to-back streaming with gaps on the valid input.

// File: rtl/bundle_issue_pkg.sv
package bundle_issue_pkg;
  localparam int TMPL_W   = 5;
  localparam int N_SLOTS  = 3;
  localparam int SLOT_W   = 41;
  localparam int BUNDLE_W = TMPL_W + N_SLOTS * SLOT_W;
  localparam int N_UNITS  = 4;
  localparam int UNIT_W   = $clog2(N_UNITS);
  localparam int IDX_W    = $clog2(N_SLOTS + 1);
  localparam int OPC_W    = 4;
  localparam int MOD_W    = 10;
  localparam int REG_W    = 7;
  localparam int PRED_W   = 6;

  typedef enum logic [UNIT_W-1:0] {
    UNIT_INT = 2'd0,
    UNIT_MEM = 2'd1,
    UNIT_BR  = 2'd2,
    UNIT_FP  = 2'd3
  } unit_e;

  // msb first: matches slot bit layout
  typedef struct packed {
    logic [OPC_W-1:0]  opc;
    logic [MOD_W-1:0]  modf;
    logic [REG_W-1:0]  dst;
    logic [REG_W-1:0]  src1;
    logic [REG_W-1:0]  src2;
    logic [PRED_W-1:0] pred;
  } slot_fields_t;
endpackage

// File: rtl/bundle_tmpl_dec.sv
module bundle_tmpl_dec
  import bundle_issue_pkg::*;
(
  input  logic [TMPL_W-1:0]                tmpl_i,
  output logic [N_SLOTS-1:0][UNIT_W-1:0]   unit_o,
  output logic [N_SLOTS-1:0]               stop_o,
  output logic                             illegal_o
);
  always_comb begin
    illegal_o = tmpl_i[4];
    unit_o[0] = UNIT_MEM;
    unit_o[1] = UNIT_INT;
    unit_o[2] = UNIT_INT;
    unique case (tmpl_i[3:2])
      2'd0: ;
      2'd1: unit_o[1] = UNIT_MEM;
      2'd2: unit_o[1] = UNIT_FP;
      2'd3: unit_o[2] = UNIT_BR;
      default: ;
    endcase
    // stop after the last slot is implied by bundle end
    stop_o = {1'b0, tmpl_i[1], tmpl_i[0]};
  end
endmodule

// File: rtl/bundle_group_sel.sv
module bundle_group_sel
  import bundle_issue_pkg::*;
(
  input  logic [N_SLOTS-1:0]               pend_i,
  input  logic [N_SLOTS-1:0][UNIT_W-1:0]   unit_i,
  input  logic [N_SLOTS-1:0]               stop_i,
  output logic [N_SLOTS-1:0]               grp_o
);
  always_comb begin
    logic               done;
    logic [N_UNITS-1:0] used;
    done  = 1'b0;
    used  = '0;
    grp_o = '0;
    for (int i = 0; i < N_SLOTS; i++) begin
      if (pend_i[i] && !done) begin
        if (used[unit_i[i]]) begin
          done = 1'b1;  // unit conflict: this and later slots wait
        end else begin
          grp_o[i]         = 1'b1;
          used[unit_i[i]]  = 1'b1;
          if (stop_i[i]) done = 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/issue_port_mux.sv
module issue_port_mux
  import bundle_issue_pkg::*;
(
  input  logic [N_SLOTS-1:0][SLOT_W-1:0]   slots_i,
  input  logic [N_SLOTS-1:0]               grp_i,
  input  logic [N_SLOTS-1:0][UNIT_W-1:0]   unit_i,
  output logic [N_UNITS-1:0]               vld_o,
  output logic [N_UNITS-1:0][IDX_W-1:0]    idx_o,
  output slot_fields_t [N_UNITS-1:0]       fld_o
);
  for (genvar u = 0; u < N_UNITS; u++) begin : g_port
    logic             sel_vld;
    logic [IDX_W-1:0] sel_idx;
    always_comb begin
      sel_vld = 1'b0;
      sel_idx = '0;
      for (int i = 0; i < N_SLOTS; i++) begin
        if (grp_i[i] && (unit_i[i] == UNIT_W'(u))) begin
          sel_vld = 1'b1;
          sel_idx = IDX_W'(i);
        end
      end
    end
    assign vld_o[u] = sel_vld;
    assign idx_o[u] = sel_idx;
    assign fld_o[u] = sel_vld ? slot_fields_t'(slots_i[sel_idx]) : '0;
  end
endmodule

// File: rtl/bundle_issue_unit.sv
module bundle_issue_unit
  import bundle_issue_pkg::*;
(
  input  logic                            clk_i,
  input  logic                            rst_ni,
  input  logic                            bnd_vld_i,
  input  logic [BUNDLE_W-1:0]             bnd_i,
  output logic                            bnd_rdy_o,
  output logic                            illegal_o,
  output logic [N_UNITS-1:0]              iss_vld_o,
  output logic [N_UNITS-1:0][IDX_W-1:0]   iss_idx_o,
  output logic [N_UNITS-1:0][OPC_W-1:0]   iss_opc_o,
  output logic [N_UNITS-1:0][PRED_W-1:0]  iss_pred_o,
  output logic [N_UNITS-1:0][REG_W-1:0]   iss_dst_o,
  output logic [N_UNITS-1:0][REG_W-1:0]   iss_src1_o,
  output logic [N_UNITS-1:0][REG_W-1:0]   iss_src2_o,
  output logic [N_UNITS-1:0][MOD_W-1:0]   iss_mod_o
);
  logic                            full_q;
  logic [N_SLOTS-1:0]              pend_q;
  logic [BUNDLE_W-1:0]             bnd_q;
  logic [N_SLOTS-1:0][SLOT_W-1:0]  slots;
  logic [N_SLOTS-1:0][UNIT_W-1:0]  unit;
  logic [N_SLOTS-1:0]              stop;
  logic [N_SLOTS-1:0]              pend_eff;
  logic [N_SLOTS-1:0]              grp;
  logic                            tmpl_ill;
  logic                            accept;
  slot_fields_t [N_UNITS-1:0]      fld;

  for (genvar k = 0; k < N_SLOTS; k++) begin : g_slot
    assign slots[k] = bnd_q[TMPL_W + k*SLOT_W +: SLOT_W];
  end

  bundle_tmpl_dec u_dec (
    .tmpl_i    (bnd_q[TMPL_W-1:0]),
    .unit_o    (unit),
    .stop_o    (stop),
    .illegal_o (tmpl_ill)
  );

  assign pend_eff = (full_q && !tmpl_ill) ? pend_q : '0;

  bundle_group_sel u_sel (
    .pend_i (pend_eff),
    .unit_i (unit),
    .stop_i (stop),
    .grp_o  (grp)
  );

  issue_port_mux u_mux (
    .slots_i (slots),
    .grp_i   (grp),
    .unit_i  (unit),
    .vld_o   (iss_vld_o),
    .idx_o   (iss_idx_o),
    .fld_o   (fld)
  );

  for (genvar u = 0; u < N_UNITS; u++) begin : g_out
    assign iss_opc_o[u]  = fld[u].opc;
    assign iss_pred_o[u] = fld[u].pred;
    assign iss_dst_o[u]  = fld[u].dst;
    assign iss_src1_o[u] = fld[u].src1;
    assign iss_src2_o[u] = fld[u].src2;
    assign iss_mod_o[u]  = fld[u].modf;
  end

  assign illegal_o = full_q && tmpl_ill;
  assign bnd_rdy_o = !full_q || tmpl_ill || (grp == pend_q);
  assign accept    = bnd_vld_i && bnd_rdy_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      full_q <= 1'b0;
      pend_q <= '0;
      bnd_q  <= '0;
    end else if (accept) begin
      full_q <= 1'b1;
      pend_q <= '1;
      bnd_q  <= bnd_i;
    end else if (full_q) begin
      if (tmpl_ill) begin
        full_q <= 1'b0;
        pend_q <= '0;
      end else begin
        full_q <= |(pend_q & ~grp);
        pend_q <= pend_q & ~grp;
      end
    end
  end
endmodule

// File: rtl/bundle_issue_unit_chk.sv
module bundle_issue_unit_chk
  import bundle_issue_pkg::*;
(
  input logic                            clk_i,
  input logic                            rst_ni,
  input logic                            bnd_vld_i,
  input logic                            bnd_rdy_o,
  input logic                            illegal_o,
  input logic [N_UNITS-1:0]              iss_vld_o,
  input logic [N_UNITS-1:0][IDX_W-1:0]   iss_idx_o
);
  a_r7_illegal_no_issue: assert property (@(posedge clk_i) disable iff (!rst_ni)
    illegal_o |-> (iss_vld_o == '0));

  a_r7_illegal_frees_input: assert property (@(posedge clk_i) disable iff (!rst_ni)
    illegal_o |-> bnd_rdy_o);

  a_r8_accept_acts_next: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bnd_vld_i && bnd_rdy_o) |=> ((|iss_vld_o) || illegal_o));

  a_r5_busy_issues: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !bnd_rdy_o |-> (|iss_vld_o));

  a_r6_busy_continues: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !bnd_rdy_o |=> ((|iss_vld_o) && !illegal_o));

  for (genvar u = 0; u < N_UNITS; u++) begin : g_port_chk
    a_r1_idx_in_range: assert property (@(posedge clk_i) disable iff (!rst_ni)
      iss_vld_o[u] |-> (iss_idx_o[u] < IDX_W'(N_SLOTS)));
    if (u != int'(UNIT_MEM)) begin : g_not_mem
      a_r2_slot0_only_mem: assert property (@(posedge clk_i) disable iff (!rst_ni)
        iss_vld_o[u] |-> (iss_idx_o[u] != '0));
    end
  end
endmodule

bind bundle_issue_unit bundle_issue_unit_chk chk_i (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .bnd_vld_i (bnd_vld_i),
  .bnd_rdy_o (bnd_rdy_o),
  .illegal_o (illegal_o),
  .iss_vld_o (iss_vld_o),
  .iss_idx_o (iss_idx_o)
);

// File: tb/bundle_issue_unit_tb_top.sv
module bundle_issue_unit_tb_top;
  import bundle_issue_pkg::*;

  localparam int CLK_PERIOD = 10;
  localparam int WD_CYCLES  = 20000;

  logic clk = 1'b0;
  logic rst_ni;
  logic bnd_vld_i;
  logic [BUNDLE_W-1:0] bnd_i;
  logic bnd_rdy_o, illegal_o;
  logic [N_UNITS-1:0]             iss_vld_o;
  logic [N_UNITS-1:0][IDX_W-1:0]  iss_idx_o;
  logic [N_UNITS-1:0][OPC_W-1:0]  iss_opc_o;
  logic [N_UNITS-1:0][PRED_W-1:0] iss_pred_o;
  logic [N_UNITS-1:0][REG_W-1:0]  iss_dst_o, iss_src1_o, iss_src2_o;
  logic [N_UNITS-1:0][MOD_W-1:0]  iss_mod_o;

  always #(CLK_PERIOD/2) clk = ~clk;

  bundle_issue_unit dut_i (
    .clk_i(clk), .rst_ni(rst_ni), .bnd_vld_i(bnd_vld_i), .bnd_i(bnd_i),
    .bnd_rdy_o(bnd_rdy_o), .illegal_o(illegal_o), .iss_vld_o(iss_vld_o),
    .iss_idx_o(iss_idx_o), .iss_opc_o(iss_opc_o), .iss_pred_o(iss_pred_o),
    .iss_dst_o(iss_dst_o), .iss_src1_o(iss_src1_o), .iss_src2_o(iss_src2_o),
    .iss_mod_o(iss_mod_o)
  );

  int compared = 0;
  int mismatched = 0;
  bit done = 0;

  task automatic check(input bit ok, input string tag, input longint act, input longint exp);
    compared++;
    if (!ok) begin
      mismatched++;
      $display("FAIL %s at %0t: actual %0h expected %0h", tag, $time, act, exp);
    end
  endtask

  // R2: unit type of slot k
  function automatic int unit_of(input logic [4:0] t, input int k);
    if (k == 0) return 1;
    if (k == 1) return (t[3:2] == 2'd1) ? 1 : (t[3:2] == 2'd2) ? 3 : 0;
    return (t[3:2] == 2'd3) ? 2 : 0;
  endfunction

  // R3: stop after slot k
  function automatic bit stop_after(input logic [4:0] t, input int k);
    if (k == 0) return t[0];
    if (k == 1) return t[1];
    return 1'b0;
  endfunction

  function automatic logic [BUNDLE_W-1:0] make_bundle(input int n, input logic [4:0] t);
    logic [BUNDLE_W-1:0] b;
    b = '0;
    b[4:0] = t;
    for (int k = 0; k < 3; k++) begin
      logic [40:0] s;
      s[40:37] = 4'((n + k * 5) & 15);
      s[36:27] = 10'((n * 37 + k * 11 + 1) & 1023);
      s[26:20] = 7'((n * 3 + k + 2) & 127);
      s[19:13] = 7'((n * 13 + k * 29 + 3) & 127);
      s[12:6]  = 7'((n * 17 + k * 7 + 4) & 127);
      s[5:0]   = 6'((n * 5 + k * 7) & 63);
      b[5 + 41*k +: 41] = s;
    end
    return b;
  endfunction

  // reference model state
  bit m_full = 0;
  logic [2:0] m_pend = '0;
  logic [BUNDLE_W-1:0] m_b = '0;
  bit e_rdy, e_ill;
  logic [2:0] e_grp;
  logic [3:0] e_vld;
  int e_idx [4];

  task automatic model_expect();
    logic [4:0] t;
    bit blocked;
    logic [3:0] used;
    e_rdy = 1; e_ill = 0; e_grp = '0; e_vld = '0;
    for (int u = 0; u < 4; u++) e_idx[u] = 0;
    if (m_full) begin
      t = m_b[4:0];
      if (t[4]) e_ill = 1;
      else begin
        blocked = 0; used = '0;
        for (int k = 0; k < 3; k++) begin
          if (m_pend[k] && !blocked) begin
            if (used[unit_of(t, k)]) blocked = 1;
            else begin
              e_grp[k] = 1; used[unit_of(t, k)] = 1;
              e_vld[unit_of(t, k)] = 1; e_idx[unit_of(t, k)] = k;
              if (stop_after(t, k)) blocked = 1;
            end
          end
        end
        e_rdy = (e_grp == m_pend);
      end
    end
  endtask

  task automatic compare_outputs();
    model_expect();
    check(bnd_rdy_o == e_rdy, "R8 ready", longint'(bnd_rdy_o), longint'(e_rdy));
    check(illegal_o == e_ill, "R7 illegal", longint'(illegal_o), longint'(e_ill));
    check(iss_vld_o == e_vld, "R2_R3_R4_R5_R6 issue valid", longint'(iss_vld_o), longint'(e_vld));
    for (int u = 0; u < 4; u++) begin
      if (e_vld[u] && iss_vld_o[u]) begin
        logic [40:0] s;
        s = m_b[5 + 41*e_idx[u] +: 41];
        check(iss_idx_o[u] == IDX_W'(e_idx[u]), "R1 idx", longint'(iss_idx_o[u]), longint'(e_idx[u]));
        check(iss_opc_o[u] == s[40:37], "R1 opcode", longint'(iss_opc_o[u]), longint'(s[40:37]));
        check(iss_mod_o[u] == s[36:27], "R1 modifiers", longint'(iss_mod_o[u]), longint'(s[36:27]));
        check(iss_dst_o[u] == s[26:20], "R1 dst", longint'(iss_dst_o[u]), longint'(s[26:20]));
        check(iss_src1_o[u] == s[19:13], "R1 src1", longint'(iss_src1_o[u]), longint'(s[19:13]));
        check(iss_src2_o[u] == s[12:6], "R1 src2", longint'(iss_src2_o[u]), longint'(s[12:6]));
        check(iss_pred_o[u] == s[5:0], "R1 pred", longint'(iss_pred_o[u]), longint'(s[5:0]));
      end
    end
  endtask

  initial begin
    logic [BUNDLE_W-1:0] bq[$];
    bit acc;
    int cyc;
    rst_ni = 0; bnd_vld_i = 0; bnd_i = '0;
    // all 32 template codes in order, then a scrambled mix
    for (int n = 0; n < 32; n++) bq.push_back(make_bundle(n, 5'(n)));
    for (int n = 32; n < 96; n++) bq.push_back(make_bundle(n, 5'((n * 7) % 32)));

    repeat (3) begin
      @(negedge clk);
      check(bnd_rdy_o == 1'b1, "R9 reset ready", longint'(bnd_rdy_o), 1);
      check(illegal_o == 1'b0, "R9 reset illegal", longint'(illegal_o), 0);
      check(iss_vld_o == '0, "R9 reset issue", longint'(iss_vld_o), 0);
    end
    rst_ni = 1;

    cyc = 0;
    while ((bq.size() != 0 || m_full || bnd_vld_i) && cyc < 5000) begin
      @(negedge clk);
      cyc++;
      compare_outputs();
      // choose inputs for the coming edge; hold an unaccepted bundle
      if (!bnd_vld_i) begin
        if (bq.size() != 0 && (cyc % 7) != 3) begin
          bnd_vld_i = 1; bnd_i = bq.pop_front();
        end
      end
      model_expect();
      acc = bnd_vld_i && e_rdy;
      if (acc) begin
        m_full = 1; m_pend = 3'b111; m_b = bnd_i;
      end else if (m_full) begin
        if (e_ill) begin m_full = 0; m_pend = '0; end
        else begin m_pend = m_pend & ~e_grp; m_full = (m_pend != 0); end
      end
      @(posedge clk);
      #1;
      if (acc) begin bnd_vld_i = 0; bnd_i = '0; end
    end
    @(negedge clk);
    compare_outputs();
    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    repeat (WD_CYCLES) @(posedge clk);
    if (!done) begin
      mismatched++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end
endmodule